// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block is the receive side of a write-only three-wire serial slave: an active-low select, a serial clock and one data line. Each time the select goes low, a window opens. The block samples the data line on falling edges of the serial clock, most significant bit first, and assembles a 24-bit frame. The frame is one command byte followed by a 16-bit data word. The frame is handed over on the 24th falling edge of the window, without waiting for the select to rise.

The hand-over is a one-cycle strobe in the system clock domain. The strobe carries the command field, the data field and a flag. The flag says whether the active-low clear input was seen low at any point of the window. The register logic downstream uses that flag to drop commands that clear activity must block. The serial pins are asynchronous to the system clock and pass through a synchroniser of configurable depth first.

Clock edges beyond the 24th are ignored until the select goes high and low again. A window that ends with fewer than 24 edges produces nothing. Serial clock activity while the select is high has no effect.

Top module: `spi_frame_rx`

## Requirements
- R1: While reset is asserted and afterwards until the first frame completes, `frm_valid_o` is 0 and `frm_cmd_o`, `frm_data_o` and `frm_clr_o` are 0.
- R2: Bits are taken from `din_i` at falling edges of `sclk_i` while `cs_n_i` is low, MSB first. The first 8 bits form `frm_cmd_o`, with the first bit landing in bit 7. The next 16 bits form `frm_data_o`, with bit 8 of the window landing in bit 15.
- R3: On the 24th falling edge of a window, `frm_valid_o` rises for exactly one system-clock cycle. This happens within SYNC_STAGES+3 system clocks of that edge and while `cs_n_i` is still low.
- R4: Falling edges after the 24th in the same window are ignored: there is no second strobe, and the delivered fields hold the first 24 bits.
- R5: A window that closes (`cs_n_i` rises) after fewer than 24 falling edges gives no strobe. The next window starts counting from zero.
- R6: `sclk_i` edges while `cs_n_i` is high are not counted and give no strobe.
- R7: `frm_clr_o` is 1 with a strobe if `clr_n_i` was low at any time while the window was open, up to and including the strobe. It is 0 if `clr_n_i` was low only while `cs_n_i` was high.
- R8: `frm_cmd_o`, `frm_data_o` and `frm_clr_o` change only in the cycle where `frm_valid_o` is 1, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select (asynchronous) |
| sclk_i | input | 1 | Serial clock, sampled on falling edges (asynchronous) |
| din_i | input | 1 | Serial data, MSB first (asynchronous) |
| clr_n_i | input | 1 | Active-low clear activity input (asynchronous) |
| frm_valid_o | output | 1 | One-cycle strobe for a completed frame |
| frm_cmd_o | output | CMD_W | Command byte of the last frame |
| frm_data_o | output | DATA_W | Data word of the last frame |
| frm_clr_o | output | 1 | Clear was seen during the last frame's window |

## Verification
Assertions check the following on every cycle:
- the bit counter never passes the frame length;
- the counter is cleared whenever the select is seen high;
- a saturated counter never produces a strobe;
- the strobe never lasts two cycles;
- the clear-activity flag is set after any low clear sample inside a window;
- the output fields hold between strobes.

The bench's scenarios show the rest:
- MSB-first field placement for several patterns;
- a strobe arriving before the select rises;
- over-long and short windows;
- clock activity while the select is high being ignored;
- the flag telling a clear inside the window from one outside it.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

   localparam int DEF_CMD_W       = 8;
   localparam int DEF_DATA_W      = 16;
   localparam int DEF_SYNC_STAGES = 2;

   // width needed to hold the values 0..n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_shift_ctl.sv
module spi_shift_ctl #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               sclk_s,
   input  logic               din_s,
   output logic               load_o,
   output logic [FRAME_W-1:0] frame_o
);

   import spi_frame_pkg::*;

   localparam int CNT_W = cnt_width(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_W);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("spi_shift_ctl: FRAME_W must be at least 2");
   end

   logic               sclk_d;
   logic               fall;
   logic [CNT_W-1:0]   cnt_q;
   logic [FRAME_W-2:0] shreg_q;
   logic               take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign fall   = sclk_d & ~sclk_s;
   assign take   = fall & ~cs_s & (cnt_q != FULL);
   assign load_o = take & (cnt_q == LAST_BIT);
   assign frame_o = {shreg_q, din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (cs_s) begin
         cnt_q   <= '0;
      end else if (take) begin
         cnt_q   <= cnt_q + 1'b1;
         shreg_q <= {shreg_q[FRAME_W-3:0], din_s};
      end
   end

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (cnt_q == '0));

   assert_no_load_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL) |-> !load_o);

   assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);

endmodule

// File: rtl/spi_clr_track.sv
module spi_clr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic clr_s,
   output logic hit_o
);

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_q <= 1'b0;
      else if (cs_s)   seen_q <= 1'b0;
      else if (!clr_s) seen_q <= 1'b1;
   end

   // include a clear that is low in the very cycle of the hand-over
   assign hit_o = seen_q | ~clr_s;

   assert_clr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && !clr_s) |=> seen_q);

   assert_clr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !seen_q);

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
   parameter int CMD_W       = spi_frame_pkg::DEF_CMD_W,
   parameter int DATA_W      = spi_frame_pkg::DEF_DATA_W,
   parameter int SYNC_STAGES = spi_frame_pkg::DEF_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              din_i,
   input  logic              clr_n_i,
   output logic              frm_valid_o,
   output logic [CMD_W-1:0]  frm_cmd_o,
   output logic [DATA_W-1:0] frm_data_o,
   output logic              frm_clr_o
);

   localparam int FRAME_W = CMD_W + DATA_W;

   if (CMD_W < 1 || DATA_W < 1) begin : g_bad_fields
      $error("spi_frame_rx: CMD_W and DATA_W must be positive");
   end

   logic cs_s, sclk_s, din_s, clr_s;
   logic load;
   logic clr_hit;
   logic [FRAME_W-1:0] frame;

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_din (
      .clk(clk), .rst_n(rst_n), .d_i(din_i), .q_o(din_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_clr (
      .clk(clk), .rst_n(rst_n), .d_i(clr_n_i), .q_o(clr_s));

   spi_shift_ctl #(.FRAME_W(FRAME_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .din_s(din_s),
      .load_o(load), .frame_o(frame));

   spi_clr_track i_clr (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .clr_s(clr_s), .hit_o(clr_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_valid_o <= 1'b0;
         frm_cmd_o   <= '0;
         frm_data_o  <= '0;
         frm_clr_o   <= 1'b0;
      end else begin
         frm_valid_o <= load;
         if (load) begin
            frm_cmd_o  <= frame[FRAME_W-1:DATA_W];
            frm_data_o <= frame[DATA_W-1:0];
            frm_clr_o  <= clr_hit;
         end
      end
   end

   assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid_o |=> !frm_valid_o);

   assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid_o |-> ($stable(frm_cmd_o) && $stable(frm_data_o) && $stable(frm_clr_o)));

   assert_strobe_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid_o |-> $past(!cs_s));

endmodule

// File: tb/test_spi_frame_rx.sv
module test_spi_frame_rx;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;   // system clocks per serial clock phase

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0, clr_n = 1'b1;
   logic        frm_valid;
   logic [7:0]  frm_cmd;
   logic [15:0] frm_data;
   logic        frm_clr;

   int checks = 0, failures = 0;
   int pulses = 0, wide = 0;
   logic prev_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_frame_rx i_spi_frame_rx (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
      .clr_n_i(clr_n), .frm_valid_o(frm_valid), .frm_cmd_o(frm_cmd),
      .frm_data_o(frm_data), .frm_clr_o(frm_clr));

   always @(negedge clk) begin
      if (frm_valid) pulses++;
      if (frm_valid && prev_valid) wide++;
      prev_valid = frm_valid;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic open_win();
      cs_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic close_win();
      wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
   endtask

   // drive n bits MSB first; a clear pulse is placed in the low phase of bit clr_at
   task automatic send_bits(input logic [63:0] bits, input int n, input int clr_at);
      for (int i = 0; i < n; i++) begin
         din = bits[n-1-i];
         wait_clk(HALF);
         sclk = 1'b0;
         if (i == clr_at) clr_n = 1'b0;
         wait_clk(HALF);
         clr_n = 1'b1;
         sclk = 1'b1;
      end
   endtask

   task automatic t_reset();
      chk("R1 valid", frm_valid, 0);
      chk("R1 cmd", frm_cmd, 0);
      chk("R1 data", frm_data, 0);
      chk("R1 clr", frm_clr, 0);
   endtask

   task automatic t_frame(input logic [7:0] c, input logic [15:0] d);
      int p0 = pulses;
      open_win();
      send_bits({40'd0, c, d}, 24, -1);
      wait_clk(4);
      chk("R3 strobe before cs rises", pulses - p0, 1);
      chk("R2 cmd", frm_cmd, c);
      chk("R2 data", frm_data, d);
      chk("R7 no clear", frm_clr, 0);
      close_win();
      chk("R8 fields hold", {frm_cmd, frm_data}, {c, d});
   endtask

   task automatic t_long();
      int p0 = pulses;
      open_win();
      send_bits({32'd0, 8'h5A, 16'hC3E1, 8'hFF}, 32, -1);
      close_win();
      chk("R4 single strobe", pulses - p0, 1);
      chk("R4 cmd first bits", frm_cmd, 8'h5A);
      chk("R4 data first bits", frm_data, 16'hC3E1);
   endtask

   task automatic t_short();
      int p0 = pulses;
      open_win();
      send_bits(64'hFFFFF, 20, -1);
      close_win();
      chk("R5 no strobe", pulses - p0, 0);
      chk("R8 hold after short", frm_cmd, 8'h5A);
      t_frame(8'h0F, 16'h00F0);   // R5 next window counts from zero
   endtask

   task automatic t_cs_high();
      int p0 = pulses;
      din = 1'b1;
      send_bits(64'hFFFF_FFFF, 30, -1);
      wait_clk(2*HALF);
      chk("R6 no strobe with cs high", pulses - p0, 0);
      t_frame(8'h81, 16'h7E42);
   endtask

   task automatic t_clear();
      open_win();
      send_bits({40'd0, 8'h11, 16'h2233}, 24, 10);
      wait_clk(4);
      chk("R7 clear in window", frm_clr, 1);
      close_win();
      clr_n = 1'b0; wait_clk(HALF); clr_n = 1'b1; wait_clk(HALF);
      open_win();
      send_bits({40'd0, 8'h44, 16'h5566}, 24, -1);
      wait_clk(4);
      chk("R7 clear outside window", frm_clr, 0);
      chk("R7 data", frm_data, 16'h5566);
      close_win();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait_clk(3);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_frame(8'hA5, 16'h1234);
      t_frame(8'h3C, 16'hFFFF);
      t_frame(8'h00, 16'h8001);
      t_long();
      t_short();
      t_cs_high();
      t_clear();
      chk("R3 strobe one cycle", wide, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule